// File: doc/BRIEF.md
# Four-Output Bridge Steering with Direction Dead Band

This block turns one pulse-width-modulated data line into drive for the four switches of a full H-bridge. One direction bit chooses which diagonal pair conducts. In forward direction output A is held on and output B follows the data. In reverse direction output C is held on and output D follows the data. The data line may be asynchronous to the block clock, so it is resampled by a short synchroniser, and all edge decisions use the resampled copy.

The direction bit can be changed at any moment. The block only acts on a change at the next rising edge of the resampled data. At that edge the two steady outputs swap at once. The modulated output of the new direction stays off for a programmed number of clock cycles before it starts to follow the data. A switch into reverse uses the rising-event count. A switch back into forward uses the falling-event count. This gap is applied only to the first pulse after a reversal. Because the data is resampled, the real dead time can be off by up to one clock period.

Each output has its own inversion bit, so any switch driver can be active-low.

Top module: `fb_steer`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first rising data edge, all four outputs sit at their inactive level (the value of their `pol_inv` bit). The direction is forward and no dead-band count is running.
- R2: `pwm_in` goes through a two-stage synchroniser. A level sampled at one clock edge reaches the modulated output at the second following edge.
- R3: In forward direction (`dir_rev`=0 applied), A is active from the first rising data edge on, B is active exactly when the delayed data is high, and C and D are inactive.
- R4: In reverse direction (`dir_rev`=1 applied), C is held active, D follows the delayed data, and A and B are inactive.
- R5: A change of `dir_rev` has no effect on any output until the next rising edge of the synchronised data. Changes made while the data is high or low are held off until then.
- R6: At the rising data edge that applies a new direction, A and C swap state in the same clock cycle, with no delay.
- R7: After a forward-to-reverse switch, D stays inactive for `dly_rise` clock cycles after the switch cycle and then follows the data. After a reverse-to-forward switch, B does the same using `dly_fall`.
- R8: Later pulses in the same direction have no dead band. The modulated output follows the data with only the R2 latency.
- R9: A dead-band count of 0 lets the newly modulated output go active in the same cycle as the A/C swap.
- R10: If the synchronised data falls before the dead-band count runs out, that pulse produces no active level on the modulated output and the count is cleared. The next pulse passes normally.
- R11: `pol_inv` bit 0 inverts A, bit 1 inverts B, bit 2 inverts C and bit 3 inverts D. A bit value of 0 means active-high.
- R12: A and C are never active together, and B and D are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sets the dead-band time unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Modulation data, may be asynchronous |
| dir_rev | input | 1 | Requested direction: 0 forward, 1 reverse |
| dly_rise | input | CW | Dead-band cycles when switching into reverse |
| dly_fall | input | CW | Dead-band cycles when switching into forward |
| pol_inv | input | 4 | Per-output inversion; bit 0 A, 1 B, 2 C, 3 D |
| out_a | output | 1 | Steady switch, forward direction |
| out_b | output | 1 | Modulated switch, forward direction |
| out_c | output | 1 | Steady switch, reverse direction |
| out_d | output | 1 | Modulated switch, reverse direction |

## Verification
Steady pulse trains in each direction show whether the correct pair of outputs is chosen and whether the latency is right. Direction writes placed in the high phase, the low phase and at random points show whether a change waits for the next rising edge. Switches with dead-band counts of 0, small values and values longer than the pulse show the exact start of the gap, whether it is skipped on later pulses, and whether short pulses are suppressed. Passes with mixed inversion patterns show that each inversion bit affects only its own output.

// File: rtl/fb_steer.sv
module fb_steer #(
  parameter int CW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_in,
  input  logic          dir_rev,
  input  logic [CW-1:0] dly_rise,
  input  logic [CW-1:0] dly_fall,
  input  logic [3:0]    pol_inv,
  output logic          out_a,
  output logic          out_b,
  output logic          out_c,
  output logic          out_d
);

  logic [SYNC-1:0] sy_q;
  logic            dat_dq;
  logic            dir_q;
  logic            run_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cnt_n;
  logic [3:0]      act_q;
  logic [3:0]      act_n;

  wire dat   = sy_q[SYNC-1];
  wire rise  = dat & ~dat_dq;
  wire fall  = ~dat & dat_dq;
  wire flip  = rise & (dir_rev != dir_q);
  wire dir_n = flip ? dir_rev : dir_q;
  wire run_n = run_q | rise;
  wire go    = dat & (cnt_n == '0);

  always_comb begin
    if (flip)
      cnt_n = dir_rev ? dly_rise : dly_fall;
    else if (fall || cnt_q == '0)
      cnt_n = '0;
    else
      cnt_n = cnt_q - 1'b1;
  end

  assign act_n = {go & dir_n, run_n & dir_n, go & ~dir_n, run_n & ~dir_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_q   <= '0;
      dat_dq <= 1'b0;
      dir_q  <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      act_q  <= '0;
    end else begin
      sy_q   <= {sy_q[SYNC-2:0], pwm_in};
      dat_dq <= dat;
      dir_q  <= dir_n;
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
    end
  end

  assign {out_d, out_c, out_b, out_a} = act_q ^ pol_inv;

endmodule

// File: rtl/fb_steer_chk.sv
module fb_steer_chk #(
  parameter int SYNC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_in,
  input logic [3:0] pol_inv,
  input logic       out_a,
  input logic       out_b,
  input logic       out_c,
  input logic       out_d
);

  wire a = out_a ^ pol_inv[0];
  wire b = out_b ^ pol_inv[1];
  wire c = out_c ^ pol_inv[2];
  wire d = out_d ^ pol_inv[3];

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!a && !b && !c && !d));

  assert_ac_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(a && c));

  assert_bd_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(b && d));

  assert_b_in_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    b |-> a);

  assert_d_in_reverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    d |-> c);

  assert_b_from_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b) |-> $past(pwm_in, SYNC + 1));

  assert_d_from_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d) |-> $past(pwm_in, SYNC + 1));

endmodule

bind fb_steer fb_steer_chk #(.SYNC(SYNC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pol_inv(pol_inv),
  .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
);

// File: tb/tb_fb_steer.sv
`timescale 1ns/1ps
module tb_fb_steer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm_in = 1'b0;
  logic          dir_rev = 1'b0;
  logic [CW-1:0] dly_rise = '0;
  logic [CW-1:0] dly_fall = '0;
  logic [3:0]    pol_inv = 4'b0000;
  logic          out_a, out_b, out_c, out_d;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  fb_steer #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dir_rev(dir_rev),
    .dly_rise(dly_rise), .dly_fall(dly_fall), .pol_inv(pol_inv),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
  );

  // reference model state
  int m1 = 0, m2 = 0, m3 = 0;
  int mdir = 0, started = 0, wait_left = 0;
  logic [3:0] exp_act;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0;
      mdir = 0; started = 0; wait_left = 0;
      exp_act = 4'b0000;
    end else begin
      if (m2 == 1 && m3 == 0) begin
        started = 1;
        if (int'(dir_rev) != mdir) begin
          mdir = int'(dir_rev);
          wait_left = (mdir == 1) ? int'(dly_rise) : int'(dly_fall);
        end else if (wait_left > 0) begin
          wait_left = wait_left - 1;
        end
      end else if (m2 == 0 && m3 == 1) begin
        wait_left = 0;
      end else if (wait_left > 0) begin
        wait_left = wait_left - 1;
      end
      exp_act[0] = (started == 1) && (mdir == 0);
      exp_act[2] = (started == 1) && (mdir == 1);
      exp_act[1] = (m2 == 1) && (wait_left == 0) && (mdir == 0);
      exp_act[3] = (m2 == 1) && (wait_left == 0) && (mdir == 1);
      m3 = m2; m2 = m1; m1 = int'(pwm_in);
    end
    #1;
    total++;
    if ({out_d, out_c, out_b, out_a} !== (exp_act ^ pol_inv)) begin
      bad++;
      $display("FAIL %s t=%0t outputs DCBA actual=%b expected=%b", tag, $time,
               {out_d, out_c, out_b, out_a}, exp_act ^ pol_inv);
    end
    if (rst_n) begin
      total++;
      // R12: modulated pair never both active
      if (((out_b ^ pol_inv[1]) && (out_d ^ pol_inv[3])) === 1'b1) begin
        bad++;
        $display("FAIL R12 t=%0t B and D both active actual=11 expected=not 11", $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    pwm_in = 1'b1; tick(hi);
    pwm_in = 1'b0; tick(lo);
  endtask

  task automatic rpulse(input int hi, input int lo);
    pwm_in = 1'b1;
    for (int i = 0; i < hi; i++) begin
      if ($urandom_range(0, 9) == 0) dir_rev = ~dir_rev;
      tick(1);
    end
    pwm_in = 1'b0;
    for (int i = 0; i < lo; i++) begin
      if ($urandom_range(0, 9) == 0) dir_rev = ~dir_rev;
      tick(1);
    end
  endtask

  initial begin
    tag = "R1";
    tick(5);
    rst_n = 1'b1;
    tick(6);

    tag = "R3";
    repeat (3) pulse(6, 4);
    pulse(3, 5);

    tag = "R2";
    repeat (4) pulse(1, 3);

    tag = "R7";
    dly_rise = 8'd3; dly_fall = 8'd5;
    dir_rev = 1'b1; tick(2);
    pulse(8, 6);

    tag = "R8";
    repeat (3) pulse(7, 4);

    tag = "R5";
    pwm_in = 1'b1; tick(2);
    dir_rev = 1'b0; tick(6);
    pwm_in = 1'b0; tick(4);
    tag = "R7";
    pulse(9, 5);

    tag = "R6";
    dir_rev = 1'b1; pulse(8, 4);
    pulse(5, 4);

    tag = "R9";
    dly_rise = 8'd0; dly_fall = 8'd0;
    dir_rev = 1'b0; pulse(4, 3);
    dir_rev = 1'b1; pulse(4, 3);
    pulse(4, 3);

    tag = "R10";
    dly_rise = 8'd8; dly_fall = 8'd8;
    dir_rev = 1'b0; pulse(4, 6);
    pulse(10, 4);
    dir_rev = 1'b1; pulse(2, 6);
    pulse(6, 4);

    tag = "R11";
    dly_rise = 8'd2; dly_fall = 8'd1;
    pol_inv = 4'b1010;
    pulse(5, 4);
    dir_rev = 1'b0; pulse(5, 4);
    pol_inv = 4'b0101;
    pulse(5, 4);
    dir_rev = 1'b1; pulse(5, 4);
    pol_inv = 4'b1111;
    pulse(5, 4);
    pol_inv = 4'b0000;

    tag = "R4";
    repeat (3) pulse(5, 5);

    tag = "R5";
    for (int k = 0; k < 300; k++) begin
      if (k % 25 == 0) begin
        dly_rise = CW'($urandom_range(0, 9));
        dly_fall = CW'($urandom_range(0, 9));
        pol_inv  = 4'($urandom_range(0, 15));
      end
      rpulse($urandom_range(1, 12), $urandom_range(1, 12));
    end

    tag = "R1";
    rst_n = 1'b0; pwm_in = 1'b1; dir_rev = 1'b1;
    tick(4);
    rst_n = 1'b1; pwm_in = 1'b0;
    tick(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule